// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block puts two programmable interrupt controllers into one cascade. Each controller has eight inputs. The first unit (the master) takes request lines 0 to 7 and drives the single CPU interrupt line. Its input 2 is tied inside the block to the output of the second unit (the slave), which takes request lines 8 to 15. That leaves fifteen external request lines. Each line is edge triggered. Within a unit, a lower input number wins. Because the slave enters at master input 2, the slave's lines rank below lines 0 and 1 and above lines 3 to 7.

Software programs the block through a byte-wide write port. A select bit picks the unit, and an address bit picks the command or the data location. On that port it runs the four-word initialization sequence, replaces the mask, and issues non-specific end-of-interrupt commands.

A one-cycle acknowledge strobe resolves the winning request. The 8-bit vector appears on the following cycle. The acknowledge also retires the request. Unless automatic end-of-interrupt was selected, it also marks the input as in service.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `cpu_int_o` and `vec_valid_o` are low, and both units are uninitialized with every input masked.
- R2: A command write with bit 4 set starts initialization. In that word, bit 0 = 1 means a fourth word follows, and bit 1 = 0 means a cascade word follows. The following data writes are, in order: the vector base (bits 7:3), the cascade word (only when bit 1 was clear, and it is consumed without effect), and the mode word (only when bit 0 was set). The start word also clears the in-service bits and sets the mask to all ones. A unit raises no interrupt until its sequence is complete.
- R3: After initialization, a data write replaces the unit's 8-bit mask. A set bit disables that input, and the input's request is kept.
- R4: A rising edge on a request line latches a request. A line held high does not request again after it has been acknowledged. A latched request that is masked is served once it is unmasked.
- R5: The effective priority from highest to lowest is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. `vec_o` bits 2:0 carry the winning input's index within its unit.
- R6: A one-cycle `inta_i` pulse makes `vec_valid_o` high for exactly the next cycle, with `vec_o` = (unit base & 0xF8) | index. `vec_o` holds its value until the next acknowledge.
- R7: An acknowledge while no request is eligible returns the master base with index 7 and changes no state.
- R8: Without automatic end-of-interrupt, an acknowledged input stays in service. While it is in service, requests of equal or lower priority do not raise `cpu_int_o`, and higher ones still do.
- R9: The command byte 0x20 clears the highest-priority in-service bit of the addressed unit. Any other command byte that does not start initialization has no effect.
- R10: With mode word bit 1 set (automatic end-of-interrupt), an acknowledge sets no in-service bit, so a pending lower request raises `cpu_int_o` at once.
- R11: External request line 2 is ignored.
- R12: Acknowledging a slave request puts master input 2 in service (without automatic end-of-interrupt). A further slave request waits until both units have received an end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Request lines; bit 2 is ignored |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_slave_i | input | 1 | 0 selects the master unit, 1 selects the slave unit |
| reg_a0_i | input | 1 | 0 selects the command location, 1 selects the data location |
| reg_wdata_i | input | 8 | Write data |
| inta_i | input | 1 | Interrupt acknowledge strobe (one cycle) |
| cpu_int_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | High for one cycle after each acknowledge |
| vec_o | output | 8 | Vector of the last acknowledge |

## Verification
The assertions check the following on every cycle:
- each acknowledge is followed by a one-cycle valid vector;
- the vector holds between acknowledges;
- an acknowledge with nothing eligible returns index 7;
- a master winner other than the cascade input shows up as the vector's low bits.

The merged priority order, the in-service blocking and its release through end-of-interrupt commands, and the cascade hold-off across both units depend on multi-step sequences, so only the bench scenarios show them. The same is true of edge-only latching and of the initialization ordering.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_LINES = 8;
    localparam int PIC_VEC_W = 8;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_ICW2,
        SEQ_ICW3,
        SEQ_ICW4,
        SEQ_READY
    } seq_state_e;
endpackage

// File: rtl/pic_initseq.sv
module pic_initseq
    import pic_pkg::*;
#(
    parameter int VEC_W = PIC_VEC_W,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   a0_i,
    input  logic [VEC_W-1:0]       wdata_i,
    output logic                   ready_o,
    output logic [VEC_W-IDX_W-1:0] base_o,
    output logic                   aeoi_o,
    output logic                   icw1_o,
    output logic                   mask_wr_o,
    output logic                   eoi_o
);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [VEC_W-1:0] EOI_CODE = VEC_W'(8'h20);

    typedef struct packed {
        seq_state_e        st;
        logic              need4;
        logic              single;
        logic [BASE_W-1:0] base;
        logic              aeoi;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d     = seq_q;
        icw1_o    = wr_i && !a0_i && wdata_i[4];
        mask_wr_o = wr_i && a0_i && (seq_q.st == SEQ_READY);
        eoi_o     = wr_i && !a0_i && (seq_q.st == SEQ_READY) && (wdata_i == EOI_CODE);
        if (icw1_o) begin
            seq_d.st     = SEQ_ICW2;
            seq_d.need4  = wdata_i[0];
            seq_d.single = wdata_i[1];
            seq_d.aeoi   = 1'b0;
        end else if (wr_i && a0_i) begin
            case (seq_q.st)
                SEQ_ICW2: begin
                    seq_d.base = wdata_i[VEC_W-1:IDX_W];
                    if (!seq_q.single)     seq_d.st = SEQ_ICW3;
                    else if (seq_q.need4)  seq_d.st = SEQ_ICW4;
                    else                   seq_d.st = SEQ_READY;
                end
                SEQ_ICW3: seq_d.st = seq_q.need4 ? SEQ_ICW4 : SEQ_READY;
                SEQ_ICW4: begin
                    seq_d.aeoi = wdata_i[1];
                    seq_d.st   = SEQ_READY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, need4: 1'b0, single: 1'b0, base: '0, aeoi: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready_o = (seq_q.st == SEQ_READY);
    assign base_o  = seq_q.base;
    assign aeoi_o  = seq_q.aeoi;
endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter int N         = PIC_LINES,
    parameter int VEC_W     = PIC_VEC_W,
    parameter int IS_MASTER = 1,
    parameter int CAS_POS   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  irq_i,
    input  logic                          cas_req_i,
    input  logic                          wr_i,
    input  logic                          a0_i,
    input  logic [VEC_W-1:0]              wdata_i,
    input  logic                          ack_i,
    output logic                          int_o,
    output logic [$clog2(N)-1:0]          win_o,
    output logic [VEC_W-$clog2(N)-1:0]    base_o
);
    localparam int IDX_W  = $clog2(N);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [IDX_W:0] NONE = (IDX_W+1)'(N);

    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [N-1:0] imr;
        logic [N-1:0] prev;
    } unit_t;

    unit_t u_q, u_d;

    logic              ready, aeoi, icw1, mask_wr, eoi;
    logic [BASE_W-1:0] base;
    logic [N-1:0]      ext, casv, eff;
    logic [IDX_W:0]    req_idx, isr_idx;

    pic_initseq #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .a0_i      (a0_i),
        .wdata_i   (wdata_i),
        .ready_o   (ready),
        .base_o    (base),
        .aeoi_o    (aeoi),
        .icw1_o    (icw1),
        .mask_wr_o (mask_wr),
        .eoi_o     (eoi)
    );

    // lowest set bit index = highest priority; NONE when empty
    function automatic logic [IDX_W:0] first_set(input logic [N-1:0] v);
        logic [IDX_W:0] r;
        r = NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = (IDX_W+1)'(i);
        end
        return r;
    endfunction

    always_comb begin
        ext  = irq_i;
        casv = '0;
        if (IS_MASTER != 0) begin
            ext[CAS_POS]  = 1'b0;
            casv[CAS_POS] = cas_req_i;
        end
        eff     = (u_q.irr | casv) & ~u_q.imr;
        req_idx = first_set(eff);
        isr_idx = first_set(u_q.isr);
        int_o   = ready && (req_idx < isr_idx);
        win_o   = req_idx[IDX_W-1:0];

        u_d      = u_q;
        u_d.prev = ext;
        if (ack_i && int_o) begin
            u_d.irr[win_o] = 1'b0;
            if (!aeoi) u_d.isr[win_o] = 1'b1;
        end
        if (eoi && (isr_idx != NONE)) begin
            u_d.isr[isr_idx[IDX_W-1:0]] = 1'b0;
        end
        if (icw1) begin
            u_d.isr = '0;
            u_d.imr = '1;
        end
        if (mask_wr) u_d.imr = wdata_i[N-1:0];
        u_d.irr = u_d.irr | (ext & ~u_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q <= '{irr: '0, isr: '0, imr: '1, prev: '0};
        end else begin
            u_q <= u_d;
        end
    end

    assign base_o = base;
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
    import pic_pkg::*;
#(
    parameter int N       = PIC_LINES,
    parameter int VEC_W   = PIC_VEC_W,
    parameter int CAS_POS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*N-1:0]   irq_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_slave_i,
    input  logic             reg_a0_i,
    input  logic [VEC_W-1:0] reg_wdata_i,
    input  logic             inta_i,
    output logic             cpu_int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int UNITS  = 2;
    localparam int IDX_W  = $clog2(N);
    localparam int BASE_W = VEC_W - IDX_W;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             valid;
    } out_t;

    logic              unit_int  [UNITS];
    logic              unit_ack  [UNITS];
    logic              unit_wr   [UNITS];
    logic              unit_cas  [UNITS];
    logic [IDX_W-1:0]  unit_win  [UNITS];
    logic [BASE_W-1:0] unit_base [UNITS];
    logic [VEC_W-1:0]  unit_vec  [UNITS];

    out_t out_q, out_d;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        assign unit_wr[u]  = reg_wr_i && (reg_sel_slave_i == 1'(u));
        assign unit_vec[u] = unit_int[u] ? {unit_base[u], unit_win[u]}
                                         : {unit_base[u], {IDX_W{1'b1}}};
        pic_unit #(
            .N         (N),
            .VEC_W     (VEC_W),
            .IS_MASTER ((u == 0) ? 1 : 0),
            .CAS_POS   (CAS_POS)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (irq_i[u*N +: N]),
            .cas_req_i (unit_cas[u]),
            .wr_i      (unit_wr[u]),
            .a0_i      (reg_a0_i),
            .wdata_i   (reg_wdata_i),
            .ack_i     (unit_ack[u]),
            .int_o     (unit_int[u]),
            .win_o     (unit_win[u]),
            .base_o    (unit_base[u])
        );
    end

    assign unit_cas[0] = unit_int[1];
    assign unit_cas[1] = 1'b0;
    assign unit_ack[0] = inta_i;
    assign unit_ack[1] = inta_i && unit_int[0] && (unit_win[0] == IDX_W'(CAS_POS));

    always_comb begin
        out_d       = out_q;
        out_d.valid = inta_i;
        if (inta_i) out_d.vec = unit_ack[1] ? unit_vec[1] : unit_vec[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cpu_int_o   = unit_int[0];
    assign vec_valid_o = out_q.valid;
    assign vec_o       = out_q.vec;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
    parameter int VEC_W   = 8,
    parameter int IDX_W   = 3,
    parameter int CAS_POS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inta_i,
    input logic             cpu_int_o,
    input logic             vec_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             m_int,
    input logic [IDX_W-1:0] m_win
);
    assert_ack_gives_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inta_i |=> vec_valid_o);

    assert_valid_only_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> !vec_valid_o);

    assert_vec_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_i |=> $stable(vec_o));

    assert_spurious_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !cpu_int_o) |=> (vec_o[IDX_W-1:0] == {IDX_W{1'b1}}));

    assert_master_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && m_int && (m_win != IDX_W'(CAS_POS))) |=> (vec_o[IDX_W-1:0] == $past(m_win)));
endmodule

bind pic_cascade pic_cascade_chk #(
    .VEC_W   (VEC_W),
    .IDX_W   (IDX_W),
    .CAS_POS (CAS_POS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inta_i      (inta_i),
    .cpu_int_o   (cpu_int_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o),
    .m_int       (unit_int[0]),
    .m_win       (unit_win[0])
);

// File: tb/pic_cascade_bench.sv
`timescale 1ns/1ps
module pic_cascade_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_slave_i = 1'b0;
    logic        reg_a0_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic        inta_i = 1'b0;
    logic        cpu_int_o, vec_valid_o;
    logic [7:0]  vec_o;

    int total = 0;
    int bad = 0;
    logic [7:0] v;
    logic       vv;

    always #10 clk = ~clk;

    pic_cascade u_pic_cascade (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_wr_i(reg_wr_i),
        .reg_sel_slave_i(reg_sel_slave_i), .reg_a0_i(reg_a0_i),
        .reg_wdata_i(reg_wdata_i), .inta_i(inta_i), .cpu_int_o(cpu_int_o),
        .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    // {expect interrupt, request pattern, expected vector}; base 0x20 / 0x28
    localparam logic [24:0] PRIO_TAB [10] = '{
        {1'b1, 16'h0003, 8'h20},
        {1'b1, 16'h0102, 8'h21},
        {1'b1, 16'h8108, 8'h28},
        {1'b1, 16'h8008, 8'h2F},
        {1'b1, 16'h00F8, 8'h23},
        {1'b1, 16'h0080, 8'h27},
        {1'b1, 16'h0C00, 8'h2A},
        {1'b1, 16'h4020, 8'h2E},
        {1'b1, 16'h00C2, 8'h21},
        {1'b0, 16'h0004, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic a0, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_sel_slave_i = sel; reg_a0_i = a0; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        inta_i = 1'b1;
        @(negedge clk);
        inta_i = 1'b0;
        v  = vec_o;
        vv = vec_valid_o;
    endtask

    task automatic set_irq(input logic [15:0] p);
        @(negedge clk);
        irq_i = p;
        @(negedge clk);
    endtask

    task automatic init_all(input logic [7:0] mode);
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, mode);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, mode);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cpu_int after reset", 16'(cpu_int_o), 16'h0);
        check("R1 vec_valid after reset", 16'(vec_valid_o), 16'h0);

        set_irq(16'h0001);
        check("R2 no interrupt before init", 16'(cpu_int_o), 16'h0);
        set_irq(16'h0000);

        init_all(8'h03);
        check("R2 start word masks all", 16'(cpu_int_o), 16'h0);
        wr(0, 1, 8'hFB); wr(1, 1, 8'hFF);
        check("R3 masked request held back", 16'(cpu_int_o), 16'h0);
        wr(0, 1, 8'hFA);
        check("R4 latched request served on unmask", 16'(cpu_int_o), 16'h1);
        ack();
        check("R6 valid after ack", 16'(vv), 16'h1);
        check("R6 vector irq0", 16'(v), 16'h20);
        @(negedge clk);
        check("R6 valid drops", 16'(vec_valid_o), 16'h0);
        check("R6 vector holds", 16'(vec_o), 16'h20);

        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
        foreach (PRIO_TAB[i]) begin
            set_irq(PRIO_TAB[i][23:8]);
            check("R5 R11 interrupt raised", 16'(cpu_int_o), 16'(PRIO_TAB[i][24]));
            if (PRIO_TAB[i][24]) begin
                ack();
                check("R5 winning vector", 16'(v), 16'(PRIO_TAB[i][7:0]));
            end
            for (int k = 0; k < 20 && cpu_int_o; k++) ack();
            set_irq(16'h0000);
        end

        check("R7 idle before spurious", 16'(cpu_int_o), 16'h0);
        ack();
        check("R7 spurious vector", 16'(v), 16'h27);

        set_irq(16'h0008);
        ack();
        check("R4 held line vector", 16'(v), 16'h23);
        repeat (3) @(negedge clk);
        check("R4 held line no re-request", 16'(cpu_int_o), 16'h0);
        set_irq(16'h0000);

        wr(0, 1, 8'h20);
        set_irq(16'h0020);
        check("R3 masked input silent", 16'(cpu_int_o), 16'h0);
        wr(0, 1, 8'h00);
        check("R3 unmasked input requests", 16'(cpu_int_o), 16'h1);
        ack();
        check("R3 vector irq5", 16'(v), 16'h25);
        set_irq(16'h0000);

        set_irq(16'h0050);
        ack();
        check("R10 first vector", 16'(v), 16'h24);
        check("R10 lower request at once", 16'(cpu_int_o), 16'h1);
        ack();
        check("R10 second vector", 16'(v), 16'h26);
        set_irq(16'h0000);

        init_all(8'h01);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
        set_irq(16'h0020);
        ack();
        check("R8 vector irq5", 16'(v), 16'h25);
        set_irq(16'h0000);
        set_irq(16'h0040);
        check("R8 lower blocked", 16'(cpu_int_o), 16'h0);
        set_irq(16'h0042);
        check("R8 higher passes", 16'(cpu_int_o), 16'h1);
        ack();
        check("R8 vector irq1", 16'(v), 16'h21);
        check("R8 blocked after nest", 16'(cpu_int_o), 16'h0);
        wr(0, 0, 8'h20);
        check("R9 one level retired", 16'(cpu_int_o), 16'h0);
        wr(0, 0, 8'h60);
        check("R9 other command ignored", 16'(cpu_int_o), 16'h0);
        wr(0, 0, 8'h20);
        check("R9 second level retired", 16'(cpu_int_o), 16'h1);
        ack();
        check("R9 vector irq6", 16'(v), 16'h26);
        wr(0, 0, 8'h20);
        set_irq(16'h0000);

        set_irq(16'h0200);
        ack();
        check("R12 vector irq9", 16'(v), 16'h29);
        set_irq(16'h0000);
        set_irq(16'h0400);
        check("R12 slave request waits", 16'(cpu_int_o), 16'h0);
        wr(1, 0, 8'h20);
        check("R12 slave eoi alone not enough", 16'(cpu_int_o), 16'h0);
        wr(0, 0, 8'h20);
        check("R12 released after both", 16'(cpu_int_o), 16'h1);
        ack();
        check("R12 vector irq10", 16'(v), 16'h2A);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule